// File: doc/BRIEF.md
# Three-Source Interrupt Controller

This block merges three interrupt causes into one request to the processor core. The first is an external pin; a programmable edge on it latches a pending bit. The second is a timer pending flag, which is a level. The third is a software trap strobe, raised when the core executes the all-zero opcode. The pin and timer causes are maskable: each has its own enable bit, and both also need a global enable. The trap is non-maskable.

The core sees a single request line and a 2-bit source code. It answers with a one-cycle acknowledge. On that acknowledge the controller drops the global enable by itself, and it clears the latched pending bit of the source that was taken. The timer flag belongs to the timer and is cleared there. Software sets the enable bits and the edge polarity, and clears the pin's pending bit, through a single 5-bit write port. The same five bits can be read back.

Top module: `irq_tri_ctrl`

## Requirements
- R1: After reset, irq_req is 0, irq_src is 2'b00 and cfg_rdata is 5'b00000.
- R2: A cycle with cfg_we high loads cfg_wdata[0] into the global enable, [1] into the pin enable, [2] into the timer enable and [3] into the falling-edge select. These values appear on cfg_rdata bits 0 to 3 after that clock edge.
- R3: ext_pin passes through two synchronizing flops before edge detection. When the falling-edge select is 0, a 0-to-1 change sets the pin pending bit (cfg_rdata[4]); when it is 1, a 1-to-0 change does so. The bit rises at the third rising clock edge after the change. A change in the other direction has no effect.
- R4: The pin pending bit is cleared by a write with cfg_wdata[4]=1, or by an acknowledge taken while irq_src is 2'b10. If an edge is detected in the same cycle, the set wins.
- R5: The pin source requests only when the global enable, the pin enable and the pin pending bit are all 1. The timer source requests only when the global enable, the timer enable and tmr_pend are all 1.
- R6: A one-cycle swtrap pulse latches a trap pending bit. That bit raises irq_req whatever the enable bits hold, and it is cleared by an acknowledge taken while irq_src is 2'b01. A new pulse in the same cycle wins over the clear.
- R7: Priority runs trap (2'b01), then pin (2'b10), then timer (2'b11). irq_src is 2'b00 whenever irq_req is 0.
- R8: When irq_ack and irq_req are both high, the global enable is 0 after that clock edge, even if the same cycle writes it to 1. When irq_req is low, irq_ack changes nothing.
- R9: The pin pending bit latches edges even while the global enable or the pin enable is 0. Once both are set, it raises a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_pin | input | 1 | Asynchronous external interrupt pin |
| tmr_pend | input | 1 | Timer pending flag (level) |
| swtrap | input | 1 | One-cycle strobe for the opcode-zero trap |
| cfg_we | input | 1 | Write strobe for the configuration bits |
| cfg_wdata | input | 5 | Write data: enables, edge select, pin-pending clear |
| cfg_rdata | output | 5 | Read-back: enables, edge select, pin pending bit |
| irq_req | output | 1 | Interrupt request to the core |
| irq_src | output | 2 | Source code of the winning request |
| irq_ack | input | 1 | Acknowledge from the core |

## Verification
A stuck or wrongly cleared global enable shows up in the first cycle after an acknowledge. Either irq_req stays high for a maskable source, or cfg_rdata[0] reads back the wrong value. A lost or spurious pin edge shows up on cfg_rdata[4] exactly three clocks after the pin moves. The bench compares every output on every cycle, so it reports the fault in that cycle rather than at the end of a scenario. A broken priority or trap latch is reported as a wrong irq_src, in the same cycle as the conflicting requests or in the one just after the strobe.

// File: rtl/irq_tri_pkg.sv
package irq_tri_pkg;

  typedef enum logic [1:0] {
    SRC_NONE = 2'b00,
    SRC_SW   = 2'b01,
    SRC_EXT  = 2'b10,
    SRC_TMR  = 2'b11
  } irq_src_e;

  localparam int CFG_W       = 5;
  localparam int BIT_GIE     = 0;
  localparam int BIT_EXT_EN  = 1;
  localparam int BIT_TMR_EN  = 2;
  localparam int BIT_EDGE_NG = 3;
  localparam int BIT_EXT_PND = 4;

  // Fixed priority: trap, then pin, then timer.
  function automatic irq_src_e pick_src(input logic sw, input logic ext, input logic tmr);
    if (sw)       return SRC_SW;
    else if (ext) return SRC_EXT;
    else if (tmr) return SRC_TMR;
    else          return SRC_NONE;
  endfunction

  // Edge match for the selected polarity, from the older and newer samples.
  function automatic logic edge_hit(input logic older, input logic newer, input logic neg_sel);
    return neg_sel ? (older & ~newer) : (~older & newer);
  endfunction

endpackage

// File: rtl/irq_tri_sync.sv
module irq_tri_sync
  import irq_tri_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  input  logic neg_sel_i,
  output logic edge_o
);
  localparam int CHAIN_W = STAGES + 1;

  logic [CHAIN_W-1:0] chain_q;

  generate
    for (genvar g = 0; g < CHAIN_W; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= pin_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign edge_o = edge_hit(chain_q[CHAIN_W-1], chain_q[CHAIN_W-2], neg_sel_i);

endmodule

// File: rtl/irq_tri_cfg.sv
module irq_tri_cfg
  import irq_tri_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_i,
  input  logic [CFG_W-1:0] wdata_i,
  input  logic             edge_evt_i,
  input  logic             sw_strobe_i,
  input  logic             ack_take_i,
  input  logic [1:0]       ack_src_i,
  output logic             gie_o,
  output logic             ext_en_o,
  output logic             tmr_en_o,
  output logic             neg_sel_o,
  output logic             ext_pend_o,
  output logic             sw_pend_o
);
  logic gie_q, ext_en_q, tmr_en_q, neg_q, ext_pend_q, sw_pend_q;
  logic ext_clr, sw_clr;

  assign ext_clr = (we_i & wdata_i[BIT_EXT_PND]) |
                   (ack_take_i & (ack_src_i == SRC_EXT));
  assign sw_clr  = ack_take_i & (ack_src_i == SRC_SW);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gie_q    <= 1'b0;
      ext_en_q <= 1'b0;
      tmr_en_q <= 1'b0;
      neg_q    <= 1'b0;
    end else begin
      if (we_i) begin
        ext_en_q <= wdata_i[BIT_EXT_EN];
        tmr_en_q <= wdata_i[BIT_TMR_EN];
        neg_q    <= wdata_i[BIT_EDGE_NG];
      end
      if (ack_take_i)  gie_q <= 1'b0;
      else if (we_i)   gie_q <= wdata_i[BIT_GIE];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ext_pend_q <= 1'b0;
      sw_pend_q  <= 1'b0;
    end else begin
      if (edge_evt_i)   ext_pend_q <= 1'b1;
      else if (ext_clr) ext_pend_q <= 1'b0;
      if (sw_strobe_i)  sw_pend_q  <= 1'b1;
      else if (sw_clr)  sw_pend_q  <= 1'b0;
    end
  end

  assign gie_o      = gie_q;
  assign ext_en_o   = ext_en_q;
  assign tmr_en_o   = tmr_en_q;
  assign neg_sel_o  = neg_q;
  assign ext_pend_o = ext_pend_q;
  assign sw_pend_o  = sw_pend_q;

endmodule

// File: rtl/irq_tri_arb.sv
module irq_tri_arb
  import irq_tri_pkg::*;
(
  input  logic       gie_i,
  input  logic       ext_en_i,
  input  logic       tmr_en_i,
  input  logic       ext_pend_i,
  input  logic       tmr_pend_i,
  input  logic       sw_pend_i,
  output logic       req_o,
  output logic [1:0] src_o
);
  logic ext_live, tmr_live;
  irq_src_e win;

  assign ext_live = gie_i & ext_en_i & ext_pend_i;
  assign tmr_live = gie_i & tmr_en_i & tmr_pend_i;
  assign win      = pick_src(sw_pend_i, ext_live, tmr_live);
  assign src_o    = win;
  assign req_o    = (win != SRC_NONE);

endmodule

// File: rtl/irq_tri_ctrl.sv
module irq_tri_ctrl
  import irq_tri_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_pin,
  input  logic             tmr_pend,
  input  logic             swtrap,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [CFG_W-1:0] cfg_rdata,
  output logic             irq_req,
  output logic [1:0]       irq_src,
  input  logic             irq_ack
);
  logic gie_q, ext_en, tmr_en, neg_sel, ext_pend, sw_pend;
  logic edge_evt, ack_take;

  irq_tri_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_i     (ext_pin),
    .neg_sel_i (neg_sel),
    .edge_o    (edge_evt)
  );

  assign ack_take = irq_ack & irq_req;

  irq_tri_cfg u_cfg (
    .clk         (clk),
    .rst_n       (rst_n),
    .we_i        (cfg_we),
    .wdata_i     (cfg_wdata),
    .edge_evt_i  (edge_evt),
    .sw_strobe_i (swtrap),
    .ack_take_i  (ack_take),
    .ack_src_i   (irq_src),
    .gie_o       (gie_q),
    .ext_en_o    (ext_en),
    .tmr_en_o    (tmr_en),
    .neg_sel_o   (neg_sel),
    .ext_pend_o  (ext_pend),
    .sw_pend_o   (sw_pend)
  );

  irq_tri_arb u_arb (
    .gie_i      (gie_q),
    .ext_en_i   (ext_en),
    .tmr_en_i   (tmr_en),
    .ext_pend_i (ext_pend),
    .tmr_pend_i (tmr_pend),
    .sw_pend_i  (sw_pend),
    .req_o      (irq_req),
    .src_o      (irq_src)
  );

  always_comb begin
    cfg_rdata              = '0;
    cfg_rdata[BIT_GIE]     = gie_q;
    cfg_rdata[BIT_EXT_EN]  = ext_en;
    cfg_rdata[BIT_TMR_EN]  = tmr_en;
    cfg_rdata[BIT_EDGE_NG] = neg_sel;
    cfg_rdata[BIT_EXT_PND] = ext_pend;
  end

endmodule

// File: rtl/irq_tri_chk.sv
module irq_tri_chk
  import irq_tri_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       irq_req,
  input logic [1:0] irq_src,
  input logic       irq_ack,
  input logic       gie,
  input logic       sw_pend,
  input logic       edge_evt,
  input logic       ext_pend
);

  // R8
  gie_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && irq_req) |=> !gie);

  // R6
  trap_unmasked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_pend |-> (irq_req && irq_src == SRC_SW));

  // R5
  maskable_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && irq_src != SRC_SW) |-> gie);

  // R3
  edge_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    edge_evt |=> ext_pend);

  // R4
  ext_ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && irq_req && irq_src == SRC_EXT && !edge_evt) |=> !ext_pend);

endmodule

bind irq_tri_ctrl irq_tri_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .irq_req  (irq_req),
  .irq_src  (irq_src),
  .irq_ack  (irq_ack),
  .gie      (gie_q),
  .sw_pend  (sw_pend),
  .edge_evt (edge_evt),
  .ext_pend (ext_pend)
);

// File: tb/irq_tri_ctrl_test.sv
module irq_tri_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ext_pin = 1'b0, tmr_pend = 1'b0, swtrap = 1'b0, cfg_we = 1'b0, irq_ack = 1'b0;
  logic [4:0] cfg_wdata = 5'd0;
  logic [4:0] cfg_rdata;
  logic       irq_req;
  logic [1:0] irq_src;

  int vecs = 0;
  int miss = 0;
  bit done = 0;

  // behavioural reference state
  bit m_gie, m_een, m_ten, m_neg, m_epend, m_spend;
  int pin_hist[$];

  always #5 clk = ~clk;

  irq_tri_ctrl uut (
    .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .tmr_pend(tmr_pend), .swtrap(swtrap),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .irq_req(irq_req), .irq_src(irq_src), .irq_ack(irq_ack)
  );

  function automatic bit exp_req(input bit tp);
    return m_spend || (m_gie && ((m_epend && m_een) || (tp && m_ten)));
  endfunction

  function automatic bit [1:0] exp_src(input bit tp);
    if (m_spend) return 2'd1;
    if (m_gie && m_epend && m_een) return 2'd2;
    if (m_gie && tp && m_ten) return 2'd3;
    return 2'd0;
  endfunction

  function automatic bit [4:0] exp_rd();
    return {m_epend, m_neg, m_ten, m_een, m_gie};
  endfunction

  task automatic model_reset();
    m_gie = 0; m_een = 0; m_ten = 0; m_neg = 0; m_epend = 0; m_spend = 0;
    pin_hist = '{0, 0, 0};
  endtask

  task automatic compare(input string rq, input bit tp);
    bit       er;
    bit [1:0] es;
    bit [4:0] ed;
    er = exp_req(tp); es = exp_src(tp); ed = exp_rd();
    vecs++;
    if (irq_req !== er || irq_src !== es || cfg_rdata !== ed) begin
      miss++;
      $display("FAIL %s: req/src/rdata = %b/%b/%b expected %b/%b/%b",
               rq, irq_req, irq_src, cfg_rdata, er, es, ed);
    end
  endtask

  // One cycle: drive at negedge, compare, then advance model on the posedge.
  task automatic cyc(input bit we, input bit [4:0] wd, input bit pin, input bit tp,
                     input bit sw, input bit ak, input string rq);
    bit       take, ev, older, newer;
    bit [1:0] src;
    cfg_we = we; cfg_wdata = wd; ext_pin = pin; tmr_pend = tp; swtrap = sw; irq_ack = ak;
    #1;
    compare(rq, tp);
    take = ak && exp_req(tp);
    src  = exp_src(tp);
    older = (pin_hist[2] != 0);
    newer = (pin_hist[1] != 0);
    ev = m_neg ? (older && !newer) : (!older && newer);
    @(posedge clk);
    if (sw) m_spend = 1; else if (take && src == 2'd1) m_spend = 0;
    if (ev) m_epend = 1;
    else if ((we && wd[4]) || (take && src == 2'd2)) m_epend = 0;
    if (we) begin m_een = wd[1]; m_ten = wd[2]; m_neg = wd[3]; end
    if (take) m_gie = 0; else if (we) m_gie = wd[0];
    pin_hist.push_front(pin ? 1 : 0);
    void'(pin_hist.pop_back());
    @(negedge clk);
  endtask

  task automatic idle(input int n, input bit pin, input bit tp, input string rq);
    for (int i = 0; i < n; i++) cyc(0, 5'd0, pin, tp, 0, 0, rq);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    vecs++; miss++;
    $display("FAIL watchdog R1: actual hung, expected completion");
    finish_run();
  end

  initial begin
    model_reset();
    rst_n = 0;
    repeat (3) @(negedge clk);
    compare("R1 reset", 0);
    rst_n = 1;
    idle(2, 0, 0, "R1 after reset");

    // R2: register writes read back
    cyc(1, 5'b01110, 0, 0, 0, 0, "R2 write");
    idle(1, 0, 0, "R2 readback");
    cyc(1, 5'b00011, 0, 0, 0, 0, "R2 write2");
    idle(1, 0, 0, "R2 readback2");

    // R3: rising edge with gie+ext_en set, pending after three edges
    idle(3, 1, 0, "R3 rise");
    idle(3, 1, 0, "R3 hold");
    cyc(1, 5'b10011, 1, 0, 0, 0, "R4 clear by write");
    idle(4, 0, 0, "R3 opposite edge ignored");
    // R3: falling polarity
    cyc(1, 5'b01011, 0, 0, 0, 0, "R3 select falling");
    idle(4, 1, 0, "R3 rise ignored in falling mode");
    idle(4, 0, 0, "R3 fall detected");
    // R4: ack of pin source clears pending, R8 drops gie
    cyc(0, 5'd0, 0, 0, 0, 1, "R4 ack pin");
    idle(2, 0, 0, "R8 gie cleared");
    // R4: edge and clear in same cycle: set wins
    idle(2, 1, 0, "R4 prep");
    cyc(1, 5'b11011, 1, 0, 0, 0, "R4 clear");
    idle(1, 0, 0, "R4 edge 1");
    idle(1, 0, 0, "R4 edge 2");
    cyc(1, 5'b11011, 0, 0, 0, 0, "R4 set wins over clear");
    idle(2, 0, 0, "R4 after collision");
    cyc(1, 5'b10000, 0, 0, 0, 0, "R4 clear all");

    // R5: timer gating
    idle(2, 0, 1, "R5 timer masked");
    cyc(1, 5'b00100, 0, 1, 0, 0, "R5 ten without gie");
    idle(2, 0, 1, "R5 no gie");
    cyc(1, 5'b00101, 0, 1, 0, 0, "R5 gie+ten");
    idle(2, 0, 1, "R5 timer requests");
    cyc(0, 5'd0, 0, 1, 0, 1, "R8 ack timer");
    idle(2, 0, 1, "R8 masked after ack");

    // R8: ack with simultaneous gie write, and ack without request
    cyc(1, 5'b00101, 0, 1, 0, 0, "R8 re-enable");
    cyc(1, 5'b00101, 0, 1, 0, 1, "R8 ack beats write");
    idle(1, 0, 1, "R8 check");
    cyc(0, 5'd0, 0, 0, 0, 1, "R8 ack without request");
    cyc(1, 5'b00111, 0, 0, 0, 0, "R8 enable");
    cyc(0, 5'd0, 0, 0, 0, 1, "R8 stray ack keeps gie");
    idle(1, 0, 0, "R8 gie kept");

    // R6: trap with gie off
    cyc(1, 5'b00000, 0, 0, 0, 0, "R6 all off");
    cyc(0, 5'd0, 0, 0, 1, 0, "R6 strobe");
    idle(2, 0, 0, "R6 trap unmasked");
    cyc(0, 5'd0, 0, 0, 1, 1, "R6 set beats clear");
    idle(1, 0, 0, "R6 still pending");
    cyc(0, 5'd0, 0, 0, 0, 1, "R6 ack trap");
    idle(1, 0, 0, "R6 cleared");

    // R9: edge latched while masked, then enabled
    idle(4, 1, 0, "R9 edge while masked");
    cyc(1, 5'b00011, 1, 0, 0, 0, "R9 enable");
    idle(1, 1, 0, "R9 request");

    // R7: priority
    cyc(1, 5'b00111, 1, 1, 1, 0, "R7 all enabled");
    idle(1, 1, 1, "R7 trap wins");
    cyc(0, 5'd0, 1, 1, 0, 1, "R7 ack trap");
    cyc(1, 5'b00111, 1, 1, 0, 0, "R7 re-enable");
    idle(1, 1, 1, "R7 pin over timer");
    cyc(0, 5'd0, 1, 1, 0, 1, "R7 ack pin");
    cyc(1, 5'b00111, 1, 1, 0, 0, "R7 re-enable2");
    idle(2, 1, 1, "R7 timer last");

    // mixed traffic
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      cyc(r < 8, 5'($urandom_range(0, 31)) | (r < 4 ? 5'b00001 : 5'b0),
          ($urandom_range(0, 9) < 3) ? ~ext_pin : ext_pin,
          $urandom_range(0, 3) == 0, r > 95, $urandom_range(0, 3) == 0, "R7 mixed traffic");
    end

    finish_run();
  end
endmodule